// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs an 8-bit successive-approximation conversion. It steps a trial code through a fixed sixteen-cycle sequence in a slow converter clock domain. Software starts a conversion by writing the control register on the bus side. The write strobe crosses into the converter domain through a toggle flag and a synchroniser. That start edge clears the complete flag and begins the sequence.

The sequence has two parts. For the first eight converter cycles the trial code is held at zero while the analog input settles on the sampling capacitor. Eight bit trials follow, most significant bit first. Each trial proposes one bit and keeps it only if the comparator says the input is at or above the trial code. On the last trial edge the result register is loaded and the complete flag is set.

A new write during a conversion abandons it and starts again. The comparator is treated as an ideal digital input: the DAC and the analog front end sit outside the block.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst_n` is low, and after its release with no write, `trial_code`, `result` and `conv_done` are all zero.
- R2: `conv_done` rises exactly sixteen rising converter-clock edges after the start edge, so one conversion occupies sixteen converter cycles.
- R3: A `ctl_wr` pulse captured on a bus-clock edge is acted on at the third rising converter-clock edge after that bus edge (the start edge). `conv_done` is cleared on the start edge and is unchanged before it. Done therefore rises on the nineteenth converter edge after the write.
- R4: `cmp_ge` high means the input is at or above the presented `trial_code`. The result is the largest code the comparator accepts. An input below the low reference gives 0x00, one at or above the high reference gives 0xFF, and inputs in between give the linear code.
- R5: `trial_code` stays 0x00 for the eight edges following the start edge. It becomes 0x80 on the eighth edge after start. Each later edge settles the bit just tried from `cmp_ge` and proposes the next lower bit, so on the ninth edge it reads (bit 7 result) | 0x40.
- R6: `result` keeps its previous value until the edge that sets `conv_done`, and is loaded on that same edge.
- R7: A write that arrives during a conversion aborts it. The aborted conversion never sets `conv_done`, and the new one completes nineteen converter edges after the later write.
- R8: Writes spaced at least three converter cycles apart each produce exactly one start. No write is lost and none is repeated.
- R9: Between completion and the next write, changes on `cmp_ge` have no effect: `result`, `trial_code` and `conv_done` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock for the register write strobe |
| cnv_clk | input | 1 | Converter internal clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| ctl_wr | input | 1 | One bus-cycle strobe for a write to the status/control register |
| cmp_ge | input | 1 | Comparator: high when the input is at or above `trial_code` |
| trial_code | output | 8 | Code presented to the DAC for the current trial |
| conv_done | output | 1 | Conversion-complete flag |
| result | output | 8 | Last completed conversion result |

## Verification
Four things are checked on every converter cycle:
- the start edge clears the complete flag;
- the flag rises only after exactly sixteen cycles of an unbroken sequence;
- the trial code stays zero through the sample phase and opens with the MSB alone;
- the result register and outputs move only on the completion edge or on a new start.

Only the bench scenarios can show the following:
- the exact three-edge crossing latency from a bus write;
- the converted value for inputs below, inside and above the reference range, with the comparator model closing the loop;
- that an aborted conversion never reports and that closely spaced writes neither vanish nor repeat.

// File: rtl/sar_pkg.sv
// Package: shared types for the successive-approximation sequencer.
// Assumes: nothing beyond the standard language.
package sar_pkg;

    // Sequence phase seen by the bit register.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } sar_phase_e;

endpackage

// File: rtl/sar_wr_sync.sv
// Module: carries a one-cycle bus write strobe into the converter clock
// domain as a single-cycle start pulse. The bus side flips a toggle flag;
// the converter side resynchronises it and detects the change.
// Assumes: writes are spaced by at least SYNC_STAGES+1 converter cycles,
// otherwise two toggles can cancel before they are seen.
module sar_wr_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic cnv_clk,
    input  logic rst_n,
    input  logic wr_stb,
    output logic start
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic            req_tgl;
    logic [SH_W-1:0] sync_sh;

    // Flip the request flag once per bus write.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) begin
            req_tgl <= 1'b0;
        end else if (wr_stb) begin
            req_tgl <= ~req_tgl;
        end
    end

    // Resynchronise the flag and keep one extra stage for edge detection.
    always_ff @(posedge cnv_clk) begin
        if (!rst_n) begin
            sync_sh <= '0;
        end else begin
            sync_sh <= {sync_sh[SH_W-2:0], req_tgl};
        end
    end

    // A change between the last two stages is one request.
    assign start = sync_sh[SH_W-1] ^ sync_sh[SH_W-2];

endmodule

// File: rtl/sar_step_ctrl.sv
// Module: counts the sixteen converter cycles of a conversion and reports
// the phase. A start pulse always restarts the count from zero.
// Assumes: start is a single-cycle pulse in the converter domain.
module sar_step_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 8,
    parameter int STEP_W     = $clog2(SAMPLE_CYC + DATA_W)
) (
    input  logic              cnv_clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              last,
    output sar_phase_e        phase
);

    localparam int TOTAL = SAMPLE_CYC + DATA_W;

    // Final step of the sequence.
    assign last = busy && (step == STEP_W'(TOTAL - 1));

    // Advance the step counter; start has priority over completion.
    always_ff @(posedge cnv_clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (start) begin
            busy <= 1'b1;
            step <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // Decode the phase from the counter.
    always_comb begin
        if (!busy) begin
            phase = PH_IDLE;
        end else if (step < STEP_W'(SAMPLE_CYC)) begin
            phase = PH_SAMPLE;
        end else begin
            phase = PH_TRIAL;
        end
    end

endmodule

// File: rtl/sar_bit_reg.sv
// Module: holds the trial code, the result register and the complete flag.
// Each bit is proposed one step before it is resolved from the comparator,
// MSB first, the MSB being proposed on the last sample step.
// Assumes: step and phase come from sar_step_ctrl with matching parameters.
module sar_bit_reg
    import sar_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 8,
    parameter int STEP_W     = $clog2(SAMPLE_CYC + DATA_W)
) (
    input  logic              cnv_clk,
    input  logic              rst_n,
    input  logic              start,
    input  sar_phase_e        phase,
    input  logic [STEP_W-1:0] step,
    input  logic              last,
    input  logic              cmp_ge,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] result,
    output logic              conv_done
);

    localparam int TOTAL = SAMPLE_CYC + DATA_W;

    logic [DATA_W-1:0] trial_nxt;

    // Per-bit next value: resolve from the comparator, then propose.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic bit_n;

        // Bit b is resolved on step TOTAL-1-b and proposed on TOTAL-2-b.
        always_comb begin
            bit_n = trial_code[b];
            if ((phase == PH_TRIAL) && (step == STEP_W'(TOTAL - 1 - b))) begin
                bit_n = cmp_ge;
            end
            if ((phase != PH_IDLE) && (step == STEP_W'(TOTAL - 2 - b))) begin
                bit_n = 1'b1;
            end
        end

        assign trial_nxt[b] = bit_n;
    end

    // Update trial code; load result and flag on the final step.
    always_ff @(posedge cnv_clk) begin
        if (!rst_n) begin
            trial_code <= '0;
            result     <= '0;
            conv_done  <= 1'b0;
        end else if (start) begin
            trial_code <= '0;
            conv_done  <= 1'b0;
        end else if (phase != PH_IDLE) begin
            trial_code <= trial_nxt;
            if (last) begin
                result    <= trial_nxt;
                conv_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_conv_seq.sv
// Module: top of the successive-approximation conversion sequencer.
// Joins the write-strobe crossing, the step counter and the bit register.
// Assumes: cmp_ge is a settled digital comparator decision for the
// trial_code presented in the previous converter cycle.
module sar_conv_seq
    import sar_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SAMPLE_CYC  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              cnv_clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              cmp_ge,
    output logic [DATA_W-1:0] trial_code,
    output logic              conv_done,
    output logic [DATA_W-1:0] result
);

    localparam int STEP_W = $clog2(SAMPLE_CYC + DATA_W);

    logic              start_p;
    logic              seq_busy;
    logic [STEP_W-1:0] seq_step;
    logic              seq_last;
    sar_phase_e        seq_phase;

    sar_wr_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_wr_sync (
        .bus_clk(bus_clk),
        .cnv_clk(cnv_clk),
        .rst_n  (rst_n),
        .wr_stb (ctl_wr),
        .start  (start_p)
    );

    sar_step_ctrl #(
        .DATA_W    (DATA_W),
        .SAMPLE_CYC(SAMPLE_CYC),
        .STEP_W    (STEP_W)
    ) u_step_ctrl (
        .cnv_clk(cnv_clk),
        .rst_n  (rst_n),
        .start  (start_p),
        .busy   (seq_busy),
        .step   (seq_step),
        .last   (seq_last),
        .phase  (seq_phase)
    );

    sar_bit_reg #(
        .DATA_W    (DATA_W),
        .SAMPLE_CYC(SAMPLE_CYC),
        .STEP_W    (STEP_W)
    ) u_bit_reg (
        .cnv_clk   (cnv_clk),
        .rst_n     (rst_n),
        .start     (start_p),
        .phase     (seq_phase),
        .step      (seq_step),
        .last      (seq_last),
        .cmp_ge    (cmp_ge),
        .trial_code(trial_code),
        .result    (result),
        .conv_done (conv_done)
    );

endmodule

// File: rtl/sar_conv_seq_chk.sv
// Module: property checker for sar_conv_seq, attached with bind.
// Keeps its own age counter since the last start to time completion.
// Assumes: start, busy and step are the top's internal sequence signals.
module sar_conv_seq_chk #(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 8,
    parameter int STEP_W     = 4
) (
    input logic              cnv_clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [STEP_W-1:0] step,
    input logic [DATA_W-1:0] trial_code,
    input logic [DATA_W-1:0] result,
    input logic              conv_done
);

    localparam int TOTAL = SAMPLE_CYC + DATA_W;
    localparam int AGE_W = $clog2(TOTAL) + 2;

    logic [AGE_W-1:0] age;

    // Cycles since the last start, saturating at all ones when idle.
    always_ff @(posedge cnv_clk) begin
        if (!rst_n) begin
            age <= '1;
        end else if (start) begin
            age <= '0;
        end else if (age != '1) begin
            age <= age + 1'b1;
        end
    end

    AST_DONE_AT_TOTAL: assert property (@(posedge cnv_clk) disable iff (!rst_n)
        $rose(conv_done) |-> (age == AGE_W'(TOTAL))); // R2

    AST_START_CLEARS_DONE: assert property (@(posedge cnv_clk) disable iff (!rst_n)
        start |=> !conv_done); // R3

    AST_SAMPLE_TRIAL_ZERO: assert property (@(posedge cnv_clk) disable iff (!rst_n)
        (busy && (step < STEP_W'(SAMPLE_CYC))) |-> (trial_code == '0)); // R5

    AST_MSB_FIRST: assert property (@(posedge cnv_clk) disable iff (!rst_n)
        (busy && !start && (step == STEP_W'(SAMPLE_CYC - 1)))
        |=> (trial_code == {1'b1, {(DATA_W-1){1'b0}}})); // R5

    AST_RESULT_ON_DONE: assert property (@(posedge cnv_clk) disable iff (!rst_n)
        !$stable(result) |-> $rose(conv_done)); // R6

    AST_IDLE_STABLE: assert property (@(posedge cnv_clk) disable iff (!rst_n)
        (!busy && !start)
        |=> ($stable(result) && $stable(trial_code) && $stable(conv_done))); // R9

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
    .DATA_W    (DATA_W),
    .SAMPLE_CYC(SAMPLE_CYC),
    .STEP_W    (STEP_W)
) u_chk (
    .cnv_clk   (cnv_clk),
    .rst_n     (rst_n),
    .start     (start_p),
    .busy      (seq_busy),
    .step      (seq_step),
    .trial_code(trial_code),
    .result    (result),
    .conv_done (conv_done)
);

// File: tb/sar_conv_seq_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios for sar_conv_seq, one task each.
// A behavioural comparator closes the loop: cmp_ge = (vin >= trial_code).
module sar_conv_seq_bench;

    logic       bus_clk = 1'b0;
    logic       cnv_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       ctl_wr  = 1'b0;
    logic       cmp_ge;
    logic [7:0] trial_code;
    logic       conv_done;
    logic [7:0] result;

    int vin = 0;
    int n_chk = 0;
    int n_err = 0;
    logic [7:0] prev_res = 8'h00;
    logic       prev_done = 1'b0;

    // 50 MHz bus clock; converter clock edges never coincide with bus edges.
    always #10 bus_clk = ~bus_clk;
    always #55 cnv_clk = ~cnv_clk;

    assign cmp_ge = (vin >= int'(trial_code));

    sar_conv_seq u_sar_conv_seq (
        .bus_clk   (bus_clk),
        .cnv_clk   (cnv_clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .cmp_ge    (cmp_ge),
        .trial_code(trial_code),
        .conv_done (conv_done),
        .result    (result)
    );

    // Record one check.
    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Advance to just after the next converter edge.
    task automatic cnv_step();
        @(posedge cnv_clk);
        #5;
    endtask

    // One bus-cycle write strobe; returns right after the capturing edge.
    task automatic bus_write();
        @(negedge bus_clk);
        ctl_wr = 1'b1;
        @(posedge bus_clk);
        ctl_wr <= 1'b0;
    endtask

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    // Reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) cnv_step();
        chk(trial_code == 8'h00, "R1 trial in reset", trial_code, 0);
        chk(result == 8'h00, "R1 result in reset", result, 0);
        chk(conv_done == 1'b0, "R1 done in reset", conv_done, 0);
        @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (3) cnv_step();
        chk((result == 8'h00) && !conv_done, "R1 idle after reset", result, 0);
    endtask

    // A full conversion with timing and value checks.
    task automatic t_convert(input int v);
        int exp = clamp8(v);
        vin = v;
        bus_write();
        for (int n = 1; n <= 19; n++) begin
            cnv_step();
            if (n == 2) chk(conv_done == prev_done, "R3 done before start edge", conv_done, prev_done);
            if (n == 3) chk(conv_done == 1'b0, "R3 done cleared on start edge", conv_done, 0);
            if (n == 10) chk(trial_code == 8'h00, "R5 sample phase code", trial_code, 0);
            if (n == 11) chk(trial_code == 8'h80, "R5 MSB trial", trial_code, 8'h80);
            if (n == 12) chk(trial_code == ((exp & 8'h80) | 8'h40), "R5 second trial",
                             trial_code, (exp & 8'h80) | 8'h40);
            if (n == 18) begin
                chk(conv_done == 1'b0, "R2 done not early", conv_done, 0);
                chk(result == prev_res, "R6 result held", result, prev_res);
            end
            if (n == 19) begin
                chk(conv_done == 1'b1, "R2 done after sixteen cycles", conv_done, 1);
                chk(result == exp[7:0], "R4 converted value", result, exp);
            end
        end
        prev_res  = result;
        prev_done = conv_done;
    endtask

    // Second write GAP converter cycles after the first.
    task automatic t_restart(input int v1, input int v2, input int gap, input string tag);
        int exp = clamp8(v2);
        vin = v1;
        bus_write();
        repeat (gap) cnv_step();
        vin = v2;
        bus_write();
        for (int n = 1; n <= 19; n++) begin
            cnv_step();
            if (n == 11) chk(conv_done == 1'b0, {tag, " aborted run silent"}, conv_done, 0);
            if (n == 18) chk((conv_done == 1'b0) && (result == prev_res),
                             {tag, " no early completion"}, result, prev_res);
            if (n == 19) begin
                chk(conv_done == 1'b1, {tag, " restart completes"}, conv_done, 1);
                chk(result == exp[7:0], {tag, " restart value"}, result, exp);
            end
        end
        prev_res = result;
        repeat (20) cnv_step();
        chk(conv_done == 1'b1, {tag, " no repeated start"}, conv_done, 1);
        prev_done = conv_done;
    endtask

    // Comparator activity while idle has no effect.
    task automatic t_idle_ignore();
        logic [7:0] t0 = trial_code;
        for (int k = 0; k < 12; k++) begin
            vin = (k * 37) % 300;
            cnv_step();
        end
        chk(result == prev_res, "R9 result held idle", result, prev_res);
        chk(trial_code == t0, "R9 trial held idle", trial_code, t0);
        chk(conv_done == 1'b1, "R9 done held idle", conv_done, 1);
    endtask

    initial begin
        t_reset();
        t_convert(137);
        t_convert(0);
        t_convert(255);
        t_convert(1);
        t_convert(128);
        t_convert(127);
        t_convert(85);
        t_convert(-20);
        t_convert(400);
        t_idle_ignore();
        t_restart(200, 33, 8, "R7");
        t_restart(90, 250, 3, "R8");
        t_convert(170);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule